// File: doc/BRIEF.md
# Hierarchical Hypercube Prefix Combiner

The block computes the inclusive running sum of a whole cluster of elements. The cluster is built from `2^(DH-1)` six-node groups, and those groups are wired as a `(DH-1)`-dimensional hypercube. A single start pulse captures every element from a wide parallel bus. The block then works in `DH` stages.

- **Stage 1** runs a six-node scan inside every group at the same time.
- **Each later stage** joins pairs of neighbouring partitions along one more hypercube dimension. In each pair, every node of the upper partition adds the inclusive total of the lower partition, which is the value held in the last node of the lower partition.

When the last stage ends, a done flag rises. The parallel result bus then holds the running sums, and they stay there until the next start.

The first stage takes four moves. Every later stage takes `DH+1` moves, which covers the broadcast and combine steps across the hypercube. The latency from the load edge to done is therefore fixed at `4 + (DH-1)(DH+1)` clock cycles. This gives 4 cycles for `DH=1`, 7 for `DH=2` and 12 for `DH=3`. All arithmetic wraps modulo `2^W`.

Top module: `hx_prefix_cluster`

## Requirements
- R1: After reset `done_o` is 0 and every lane of `result_o` is 0.
- R2: A start pulse while idle captures `load_i` in that clock edge. Element index `i = 6s+p` (group `s`, node `p`) is taken from bits `[i*W +: W]`, and its result appears at the same bit position.
- R3: `done_o` rises exactly `4 + (DH-1)(DH+1)` clock edges after the load edge and is 0 on every edge before that.
- R4: When `done_o` is 1, lane `i` of `result_o` equals the sum of elements `0..i`.
- R5: While `done_o` is 1 and no start arrives, `done_o` and `result_o` stay unchanged.
- R6: A start pulse that arrives while a computation is running, including in its final cycle, is ignored. Neither the data nor the timing of the running computation changes.
- R7: A start pulse after completion clears `done_o` at the next edge and begins a new computation on the newly loaded data.
- R8: Sums wrap modulo `2^W`; carries out of the top bit are discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start pulse; loads `load_i` when idle |
| load_i | input | 6·2^(DH-1)·W | All elements, element `i` at `[i*W +: W]` |
| done_o | output | 1 | High once the running sums are valid |
| result_o | output | 6·2^(DH-1)·W | Inclusive running sums, lane `i` at `[i*W +: W]` |

## Verification
A new start pulse and the completion of the final merge stage can occur in the same cycle. In that cycle the controller must both finish the current run and decide what to do with the start. The bench drives start with different data exactly in the cycle before done rises. It then checks that done rises on schedule and that the result still matches the sums of the first data set. A second check issues start in the middle of a run and judges it the same way.

// File: rtl/hx_pkg.sv
package hx_pkg;
  typedef enum logic { HX_IDLE = 1'b0, HX_RUN = 1'b1 } hx_state_e;

  // total run length in clock edges after the load edge
  function automatic int hx_run_len(input int dh);
    return 4 + (dh - 1) * (dh + 1);
  endfunction
endpackage

// File: rtl/hx_ctrl.sv
module hx_ctrl #(
  parameter int DH = 3,
  localparam int SW = $clog2(DH + 1),
  localparam int MW = $clog2((DH + 1 > 4) ? DH + 1 : 4)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  output logic          load_o,
  output logic          busy_o,
  output logic          done_o,
  output logic [SW-1:0] stage_o,
  output logic [MW-1:0] move_o,
  output logic          last_move_o
);
  import hx_pkg::*;

  hx_state_e     state_q, state_nx;
  logic          done_q, done_nx;
  logic [SW-1:0] stage_q, stage_nx;
  logic [MW-1:0] move_q, move_nx;
  logic          last_move;

  // stage 1 has four moves, every later stage DH+1 moves
  assign last_move = (stage_q == SW'(1)) ? (move_q == MW'(3)) : (move_q == MW'(DH));

  always_comb begin
    state_nx = state_q;
    done_nx  = done_q;
    stage_nx = stage_q;
    move_nx  = move_q;
    if (state_q == HX_IDLE) begin
      if (start_i) begin
        state_nx = HX_RUN;
        done_nx  = 1'b0;
        stage_nx = SW'(1);
        move_nx  = '0;
      end
    end else if (last_move) begin
      move_nx = '0;
      if (stage_q == SW'(DH)) begin
        state_nx = HX_IDLE;
        done_nx  = 1'b1;
      end else begin
        stage_nx = stage_q + SW'(1);
      end
    end else begin
      move_nx = move_q + MW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= HX_IDLE;
      done_q  <= 1'b0;
      stage_q <= '0;
      move_q  <= '0;
    end else begin
      state_q <= state_nx;
      done_q  <= done_nx;
      stage_q <= stage_nx;
      move_q  <= move_nx;
    end
  end

  assign busy_o      = (state_q == HX_RUN);
  assign load_o      = (state_q == HX_IDLE) && start_i;
  assign done_o      = done_q;
  assign stage_o     = stage_q;
  assign move_o      = move_q;
  assign last_move_o = busy_o && last_move;
endmodule

// File: rtl/hx_six_scan.sv
module hx_six_scan #(
  parameter int W  = 16,
  parameter int MW = 2
) (
  input  logic [5:0][W-1:0] y_i,
  input  logic [MW-1:0]     move_i,
  output logic [5:0][W-1:0] y_o
);
  // nodes 0..2 form the upper triangle, nodes 3..5 the lower one
  always_comb begin
    y_o = y_i;
    case (move_i)
      MW'(0): begin
        y_o[1] = y_i[0] + y_i[1];
        y_o[4] = y_i[3] + y_i[4];
      end
      MW'(1): begin
        y_o[2] = y_i[1] + y_i[2];
        y_o[5] = y_i[4] + y_i[5];
      end
      MW'(3): begin
        y_o[3] = y_i[2] + y_i[3];
        y_o[4] = y_i[2] + y_i[4];
        y_o[5] = y_i[2] + y_i[5];
      end
      default: y_o = y_i; // move 2 spreads the upper total, no data change
    endcase
  end
endmodule

// File: rtl/hx_merge_add.sv
module hx_merge_add #(
  parameter int W    = 16,
  parameter int NSUB = 4,
  parameter int S    = 0,
  parameter int SW   = 2
) (
  input  logic [NSUB-1:0][W-1:0] tail_i,
  input  logic [SW-1:0]          dim_i,
  input  logic                   en_i,
  output logic [W-1:0]           add_o
);
  int mask;
  int src;

  always_comb begin
    mask  = (2 << dim_i) - 1;
    src   = (S & ~mask) | (mask >> 1);
    add_o = '0;
    if (en_i && ((S >> dim_i) & 1) == 1 && src < NSUB)
      add_o = tail_i[src];
  end
endmodule

// File: rtl/hx_prefix_cluster.sv
module hx_prefix_cluster #(
  parameter int DH = 3,
  parameter int W  = 16,
  localparam int NSUB = 1 << (DH - 1),
  localparam int NEL  = 6 * NSUB
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start_i,
  input  logic [NEL*W-1:0]   load_i,
  output logic               done_o,
  output logic [NEL*W-1:0]   result_o
);
  localparam int SW = $clog2(DH + 1);
  localparam int MW = $clog2((DH + 1 > 4) ? DH + 1 : 4);

  logic          load, busy, last_move;
  logic [SW-1:0] stage;
  logic [MW-1:0] move;
  logic [SW-1:0] dim;
  logic          merge_en;

  logic [NSUB-1:0][5:0][W-1:0] y_q, y_nx, y_ld, y_scan;
  logic [NSUB-1:0][W-1:0]      tail, addend;
  logic                        y_en;

  hx_ctrl #(.DH(DH)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start_i(start_i),
    .load_o(load), .busy_o(busy), .done_o(done_o),
    .stage_o(stage), .move_o(move), .last_move_o(last_move)
  );

  assign y_ld     = load_i;
  assign dim      = stage - SW'(2);
  assign merge_en = busy && last_move && (stage != SW'(1));

  for (genvar s = 0; s < NSUB; s++) begin : g_sub
    assign tail[s] = y_q[s][5];

    hx_six_scan #(.W(W), .MW(MW)) u_scan (
      .y_i(y_q[s]), .move_i(move), .y_o(y_scan[s])
    );

    hx_merge_add #(.W(W), .NSUB(NSUB), .S(s), .SW(SW)) u_merge (
      .tail_i(tail), .dim_i(dim), .en_i(merge_en), .add_o(addend[s])
    );
  end

  always_comb begin
    y_nx = y_q;
    if (load) begin
      y_nx = y_ld;
    end else if (stage == SW'(1)) begin
      y_nx = y_scan;
    end else begin
      for (int s = 0; s < NSUB; s++)
        for (int p = 0; p < 6; p++)
          y_nx[s][p] = y_q[s][p] + addend[s];
    end
  end

  assign y_en = load || busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    y_q <= '0;
    else if (y_en) y_q <= y_nx;
  end

  assign result_o = y_q;
endmodule

// File: rtl/hx_prefix_cluster_chk.sv
module hx_prefix_cluster_chk #(
  parameter int DH  = 3,
  parameter int NEL = 24,
  parameter int W   = 16,
  parameter int SW  = 2
) (
  input logic               clk,
  input logic               rst_n,
  input logic               start_i,
  input logic               done_o,
  input logic               busy,
  input logic [SW-1:0]      stage,
  input logic [NEL*W-1:0]   result_o
);
  localparam int RUNL = hx_pkg::hx_run_len(DH);
  logic [7:0] run_cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                run_cnt_q <= '0;
    else if (start_i && !busy) run_cnt_q <= '0;
    else if (busy)             run_cnt_q <= run_cnt_q + 8'd1;
  end

  // R3
  run_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_o) |-> (run_cnt_q == 8'(RUNL)));

  // R3
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(done_o && busy));

  // R7
  restart_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !busy) |=> !done_o);

  // R5
  hold_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !start_i) |=> ($stable(result_o) && done_o));

  // R6
  busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start_i && $past(busy)) |=> (busy || $rose(done_o)));

  // R3
  stage_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (stage >= SW'(1) && stage <= SW'(DH)));
endmodule

bind hx_prefix_cluster hx_prefix_cluster_chk #(
  .DH(DH), .NEL(NEL), .W(W), .SW($clog2(DH + 1))
) u_chk (
  .clk(clk), .rst_n(rst_n), .start_i(start_i), .done_o(done_o),
  .busy(busy), .stage(stage), .result_o(result_o)
);

// File: tb/hx_prefix_cluster_tb.sv
module hx_prefix_cluster_tb;
  localparam int DH   = 3;
  localparam int W    = 8;
  localparam int NEL  = 6 * (1 << (DH - 1));
  localparam int RUNL = 4 + (DH - 1) * (DH + 1);
  localparam int NROW = 5;
  // each row generates element i = a + b*i + c*i*i (mod 2^W)
  localparam logic [7:0] TAB [NROW][3] = '{
    '{8'd1,   8'd0,  8'd0},
    '{8'd0,   8'd1,  8'd0},
    '{8'd255, 8'd0,  8'd0},
    '{8'd5,   8'd3,  8'd7},
    '{8'd200, 8'd17, 8'd1}
  };

  logic               clk, rst_n, start;
  logic [NEL*W-1:0]   load, result;
  logic               done;
  int                 errors, checks;
  logic [NEL*W-1:0]   vec_a, vec_b;

  hx_prefix_cluster #(.DH(DH), .W(W)) u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(start), .load_i(load),
    .done_o(done), .result_o(result)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  initial begin
    #1_000_000;
    errors = errors + 1;
    checks = checks + 1;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  function automatic logic [NEL*W-1:0] gen(input int r);
    logic [NEL*W-1:0] v;
    for (int i = 0; i < NEL; i++)
      v[i*W +: W] = W'(TAB[r][0] + TAB[r][1] * i + TAB[r][2] * i * i);
    return v;
  endfunction

  function automatic logic [NEL*W-1:0] scan(input logic [NEL*W-1:0] v);
    logic [NEL*W-1:0] o;
    logic [W-1:0] acc;
    acc = '0;
    for (int i = 0; i < NEL; i++) begin
      acc = acc + v[i*W +: W];
      o[i*W +: W] = acc;
    end
    return o;
  endfunction

  task automatic check(input bit ok, input string req, input logic [NEL*W-1:0] act,
                       input logic [NEL*W-1:0] exp);
    checks = checks + 1;
    if (!ok) begin
      errors = errors + 1;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // drive start with v, leave the bench just after the load edge
  task automatic kick(input logic [NEL*W-1:0] v);
    @(negedge clk);
    load  = v;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic finish_run(input logic [NEL*W-1:0] v, input string tag);
    repeat (RUNL - 1) @(negedge clk);
    check(!done, {"R3 early ", tag}, NEL*W'(done), '0);
    @(negedge clk);
    check(done, {"R3 on time ", tag}, NEL*W'(done), 1);
    check(result == scan(v), {"R4 sums ", tag}, result, scan(v));
  endtask

  initial begin
    errors = 0;
    checks = 0;
    start  = 1'b0;
    load   = '0;
    rst_n  = 1'b0;
    repeat (3) @(negedge clk);
    // R1
    check(!done, "R1 done", NEL*W'(done), '0);
    check(result == '0, "R1 result", result, '0);
    rst_n = 1'b1;

    for (int r = 0; r < NROW; r++) begin
      vec_a = gen(r);
      kick(vec_a);
      // R7: done cleared right after the load edge
      check(!done, "R7 clear", NEL*W'(done), '0);
      finish_run(vec_a, $sformatf("row%0d", r));
      // R2: lane 0 carries element 0, last lane the full total
      check(result[0 +: W] == vec_a[0 +: W], "R2 lane0", result, vec_a);
      // R8: the all-255 row must wrap, lane 1 = 254
      if (r == 2) check(result[W +: W] == 8'd254, "R8 wrap", result, scan(vec_a));
    end

    // R5: hold for several idle cycles
    vec_b = result;
    repeat (6) @(negedge clk);
    check(done && result == vec_b, "R5 hold", result, vec_b);

    // R6: start in mid-run with other data
    vec_a = gen(3);
    vec_b = gen(4);
    kick(vec_a);
    repeat (3) @(negedge clk);
    load = vec_b; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (RUNL - 5) @(negedge clk);
    check(!done, "R6 mid early", NEL*W'(done), '0);
    @(negedge clk);
    check(done && result == scan(vec_a), "R6 mid", result, scan(vec_a));

    // R6: start in the final move cycle
    vec_a = gen(1);
    kick(vec_a);
    repeat (RUNL - 1) @(negedge clk);
    load = vec_b; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(done && result == scan(vec_a), "R6 final cycle", result, scan(vec_a));
    @(negedge clk);
    check(done && result == scan(vec_a), "R6 no restart", result, scan(vec_a));

    // R7: clean restart on new data
    kick(vec_b);
    finish_run(vec_b, "R7 restart");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule